// File: doc/BRIEF.md
# Acquisition Card Register Interface

This block is the bus-facing register file of a data-acquisition card. A host reaches it through 16-bit word or byte accesses inside a 16-byte, I/O-mapped window. Four even offsets are decoded:

- Offset 0x00 is the digital port. A read returns 16 input pins and a write latches 16 output pins.
- Offset 0x02 feeds the analog output converter.
- Offset 0x04 starts analog conversions and returns their results.
- Offset 0x06 is a status word on read and the control word on write.

The control word packs several fields. Its low bits select the analog output channel, and the next three bits select the input or encoder channel. Single bits carry enable, auto-zero, calibrate, sample/hold and clock. A two-bit load field gates transfers to the analog output.

The analog-to-digital converter sits outside the block and is reached through a start pulse, a done pulse and a data bus. Two status flags track its progress:

- Writing the control word with enable set begins a settling conversion, and its completion raises the settling flag.
- Any write to the conversion port begins a measured conversion, and its completion raises the conversion flag and captures a 13-bit two's-complement sample.

The host reads the sample as two byte reads from the conversion port, high byte first. A word read returns the whole sign-extended sample at once. The analog output converter receives a one-cycle load strobe together with the channel and the 12-bit code.

Top module: `acq_regif`

## Requirements
- R1: After reset, dout_o and ctrl_o are zero and a word read of offset 0x06 returns 0x0000 (status bit 3 = settling done, bit 4 = conversion done, all other bits zero).
- R2: A word write to offset 0x00 sets dout_o to the written word one cycle later. A word read of offset 0x00 returns din_i.
- R3: A byte write (bus_byte_i=1) to offset 0x00 or 0x06 replaces only bits [7:0] of the register, taken from bus_wdata_i[7:0]. The upper bits keep their value.
- R4: A word write to offset 0x06 sets ctrl_o to bus_wdata_i[12:0]. The field layout is:
  - [2:0] analog output channel
  - [5:3] input channel
  - 6 enable
  - 7 auto-zero
  - 8 calibrate
  - 9 sample/hold
  - 10 clock
  - [12:11] load field
- R5: Any write to offset 0x04, whatever its data, drives adc_start_o high for exactly the next cycle and clears status bit 4.
- R6: adc_done_i, while a measured conversion is pending, sets status bit 4 and captures adc_data_i as the sample.
- R7: Byte reads of offset 0x04 alternate between bits [15:8] and bits [7:0] of the sign-extended sample, returned on bus_rdata_o[7:0] with bus_rdata_o[15:8] zero. The first read after a conversion start returns the high byte.
- R8: A word read of offset 0x04 returns the sample sign-extended from bit 12 to 16 bits. It does not move the byte pointer.
- R9: A write to offset 0x06 clears status bit 4's partner, bit 3. If the new control word has bit 6 set, the write also pulses adc_start_o once, and the next adc_done_i sets bit 3, leaves bit 4 and keeps the sample. With bit 6 clear, no start pulse is issued.
- R10: A write to offset 0x02 while ctrl_o[12:11] is 2'b11 pulses dac_load_o for one cycle, with dac_chan_o = ctrl_o[2:0] and dac_data_o = bus_wdata_i[11:0]. With any other load field value, the write produces no pulse and dac_data_o is unchanged.
- R11: Writes to odd addresses or to offsets 0x08 to 0x0F change no register. Reads of those addresses return 0x0000.
- R12: adc_done_i with no conversion pending changes neither the status bits nor the sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 4 | Byte address within the window |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_byte_i | input | 1 | 1 = byte access on lane [7:0], 0 = word access |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid combinationally during the read strobe |
| din_i | input | 16 | Digital input pins |
| dout_o | output | 16 | Latched digital output pins |
| ctrl_o | output | 13 | Control word fields |
| adc_start_o | output | 1 | One-cycle conversion start |
| adc_done_i | input | 1 | Converter done pulse |
| adc_data_i | input | 13 | Converter result, two's complement |
| dac_load_o | output | 1 | One-cycle analog output load strobe |
| dac_chan_o | output | 3 | Analog output channel for the load |
| dac_data_o | output | 12 | Analog output code for the load |

## Verification
Samples are chosen to tell the cases apart:
- A negative sample (bit 12 set) followed by a positive one shows the sign extension into both the high byte and the word read.
- Three byte reads in a row, and then a fresh conversion start, distinguish a toggling pointer from a pointer that resets on start.
- A word read placed between byte reads shows that word reads leave the pointer alone.
- Settling and measured conversions are interleaved so that each done pulse must land in the right status bit, and a stray done pulse with a new data value proves the idle guard.

Analog output writes are issued with the load field set and then cleared, separating a gated strobe from an ungated one. Writes to odd and unmapped addresses carry all-ones data, so any leak into dout_o or ctrl_o would be visible.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int ADDR_W = 4;
  localparam int CTL_W  = 13;

  typedef enum logic [1:0] {
    REG_DIO = 2'd0,
    REG_DAC = 2'd1,
    REG_ADC = 2'd2,
    REG_CSR = 2'd3
  } reg_sel_e;

  // control word bit positions (decoded by neighbours)
  localparam int CB_AO_LO = 0;
  localparam int CB_CH_LO = 3;
  localparam int CB_EN    = 6;
  localparam int CB_AZ    = 7;
  localparam int CB_CAL   = 8;
  localparam int CB_SH    = 9;
  localparam int CB_CLK   = 10;
  localparam int CB_LD_LO = 11;
  localparam int CB_LD_HI = 12;

  // status word bit positions
  localparam int SB_SETTLE = 3;
  localparam int SB_CONV   = 4;
endpackage

// File: rtl/acq_addr_dec.sv
module acq_addr_dec
  import acq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic              byte_i,
  output logic              valid_o,
  output reg_sel_e          sel_o,
  output logic              wr_dio_o,
  output logic              wr_dac_o,
  output logic              wr_adc_o,
  output logic              wr_csr_o,
  output logic              rd_adc_byte_o
);
  // only even offsets in the lower half of the window are mapped
  assign valid_o = !addr_i[0] && !addr_i[ADDR_W-1];
  assign sel_o   = reg_sel_e'(addr_i[2:1]);

  always_comb begin
    wr_dio_o      = wr_i && valid_o && (sel_o == REG_DIO);
    wr_dac_o      = wr_i && valid_o && (sel_o == REG_DAC);
    wr_adc_o      = wr_i && valid_o && (sel_o == REG_ADC);
    wr_csr_o      = wr_i && valid_o && (sel_o == REG_CSR);
    rd_adc_byte_o = rd_i && byte_i && valid_o && (sel_o == REG_ADC);
  end
endmodule

// File: rtl/acq_out_regs.sv
module acq_out_regs
  import acq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DAC_W  = 12,
  parameter int CHAN_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_dio_i,
  input  logic              wr_dac_i,
  input  logic              wr_csr_i,
  input  logic              byte_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] dout_o,
  output logic [CTL_W-1:0]  ctrl_o,
  output logic              settle_req_o,
  output logic              dac_load_o,
  output logic [CHAN_W-1:0] dac_chan_o,
  output logic [DAC_W-1:0]  dac_data_o
);
  localparam int HALF = DATA_W / 2;

  logic [CTL_W-1:0]  ctrl_n;
  logic [DATA_W-1:0] dout_n;

  always_comb begin
    ctrl_n = byte_i ? {ctrl_o[CTL_W-1:HALF], wdata_i[HALF-1:0]} : wdata_i[CTL_W-1:0];
    dout_n = byte_i ? {dout_o[DATA_W-1:HALF], wdata_i[HALF-1:0]} : wdata_i;
  end

  assign settle_req_o = wr_csr_i && ctrl_n[CB_EN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_o <= '0;
      ctrl_o <= '0;
    end else begin
      if (wr_dio_i) dout_o <= dout_n;
      if (wr_csr_i) ctrl_o <= ctrl_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_load_o <= 1'b0;
      dac_chan_o <= '0;
      dac_data_o <= '0;
    end else if (wr_dac_i && (&ctrl_o[CB_LD_HI:CB_LD_LO])) begin
      dac_load_o <= 1'b1;
      dac_chan_o <= ctrl_o[CB_AO_LO +: CHAN_W];
      dac_data_o <= wdata_i[DAC_W-1:0];
    end else begin
      dac_load_o <= 1'b0;
    end
  end
endmodule

// File: rtl/acq_conv_ctrl.sv
module acq_conv_ctrl #(
  parameter int DATA_W = 16,
  parameter int ADC_W  = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_adc_i,
  input  logic              wr_csr_i,
  input  logic              settle_req_i,
  input  logic              rd_adc_byte_i,
  input  logic              adc_done_i,
  input  logic [ADC_W-1:0]  adc_data_i,
  output logic              adc_start_o,
  output logic              st_settle_o,
  output logic              st_conv_o,
  output logic              busy_o,
  output logic              ptr_hi_o,
  output logic [DATA_W-1:0] sample_o
);
  logic             start;
  logic             kind_settle;
  logic [ADC_W-1:0] sample_q;

  assign start    = wr_adc_i || settle_req_i;
  assign sample_o = {{(DATA_W-ADC_W){sample_q[ADC_W-1]}}, sample_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      adc_start_o <= 1'b0;
      busy_o      <= 1'b0;
      kind_settle <= 1'b0;
      st_settle_o <= 1'b0;
      st_conv_o   <= 1'b0;
      ptr_hi_o    <= 1'b1;
      sample_q    <= '0;
    end else begin
      adc_start_o <= start;
      if (wr_csr_i) st_settle_o <= 1'b0;
      if (start) begin
        busy_o      <= 1'b1;
        kind_settle <= !wr_adc_i;
        if (wr_adc_i) begin
          st_conv_o <= 1'b0;
          ptr_hi_o  <= 1'b1;
        end
      end else begin
        if (adc_done_i && busy_o) begin
          busy_o <= 1'b0;
          if (kind_settle) begin
            st_settle_o <= 1'b1;
          end else begin
            st_conv_o <= 1'b1;
            sample_q  <= adc_data_i;
          end
        end
        if (rd_adc_byte_i) ptr_hi_o <= !ptr_hi_o;
      end
    end
  end
endmodule

// File: rtl/acq_regif.sv
module acq_regif
  import acq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADC_W  = 13,
  parameter int DAC_W  = 12,
  parameter int CHAN_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic              bus_byte_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic [CTL_W-1:0]  ctrl_o,
  output logic              adc_start_o,
  input  logic              adc_done_i,
  input  logic [ADC_W-1:0]  adc_data_i,
  output logic              dac_load_o,
  output logic [CHAN_W-1:0] dac_chan_o,
  output logic [DAC_W-1:0]  dac_data_o
);
  localparam int HALF = DATA_W / 2;

  logic              valid;
  reg_sel_e          sel;
  logic              wr_dio, wr_dac, wr_adc, wr_csr, rd_adc_byte;
  logic              settle_req;
  logic              st_settle, st_conv, busy, ptr_hi;
  logic [DATA_W-1:0] sample;
  logic [DATA_W-1:0] word_rd;
  logic [DATA_W-1:0] status_w;

  acq_addr_dec u_dec (
    .addr_i        (bus_addr_i),
    .wr_i          (bus_wr_i),
    .rd_i          (bus_rd_i),
    .byte_i        (bus_byte_i),
    .valid_o       (valid),
    .sel_o         (sel),
    .wr_dio_o      (wr_dio),
    .wr_dac_o      (wr_dac),
    .wr_adc_o      (wr_adc),
    .wr_csr_o      (wr_csr),
    .rd_adc_byte_o (rd_adc_byte)
  );

  acq_out_regs #(.DATA_W(DATA_W), .DAC_W(DAC_W), .CHAN_W(CHAN_W)) u_out (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_dio_i     (wr_dio),
    .wr_dac_i     (wr_dac),
    .wr_csr_i     (wr_csr),
    .byte_i       (bus_byte_i),
    .wdata_i      (bus_wdata_i),
    .dout_o       (dout_o),
    .ctrl_o       (ctrl_o),
    .settle_req_o (settle_req),
    .dac_load_o   (dac_load_o),
    .dac_chan_o   (dac_chan_o),
    .dac_data_o   (dac_data_o)
  );

  acq_conv_ctrl #(.DATA_W(DATA_W), .ADC_W(ADC_W)) u_conv (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .wr_adc_i      (wr_adc),
    .wr_csr_i      (wr_csr),
    .settle_req_i  (settle_req),
    .rd_adc_byte_i (rd_adc_byte),
    .adc_done_i    (adc_done_i),
    .adc_data_i    (adc_data_i),
    .adc_start_o   (adc_start_o),
    .st_settle_o   (st_settle),
    .st_conv_o     (st_conv),
    .busy_o        (busy),
    .ptr_hi_o      (ptr_hi),
    .sample_o      (sample)
  );

  always_comb begin
    status_w            = '0;
    status_w[SB_SETTLE] = st_settle;
    status_w[SB_CONV]   = st_conv;
    unique case (sel)
      REG_DIO: word_rd = din_i;
      REG_DAC: word_rd = '0;
      REG_ADC: word_rd = sample;
      REG_CSR: word_rd = status_w;
    endcase
  end

  always_comb begin
    bus_rdata_o = '0;
    if (valid) begin
      if (!bus_byte_i)          bus_rdata_o = word_rd;
      else if (sel == REG_ADC)  bus_rdata_o[HALF-1:0] = ptr_hi ? sample[DATA_W-1:HALF] : sample[HALF-1:0];
      else                      bus_rdata_o[HALF-1:0] = word_rd[HALF-1:0];
    end
  end
endmodule

// File: rtl/acq_regif_chk.sv
module acq_regif_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  bus_addr_i,
  input logic        bus_wr_i,
  input logic        bus_rd_i,
  input logic [15:0] bus_rdata_o,
  input logic        adc_start_o,
  input logic        adc_done_i,
  input logic        dac_load_o,
  input logic        st_conv,
  input logic        st_settle
);
  a_r5_start_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == 4'h4) |=> adc_start_o);

  a_r5_start_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_start_o |-> $past(bus_wr_i));

  a_r6_conv_flag_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_conv) |-> $past(adc_done_i));

  a_r9_settle_flag_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(st_settle) |-> $past(adc_done_i));

  a_r10_load_needs_dac_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dac_load_o |-> $past(bus_wr_i && bus_addr_i == 4'h2));

  a_r11_unmapped_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && (bus_addr_i[0] || bus_addr_i[3])) |-> bus_rdata_o == 16'h0000);
endmodule

bind acq_regif acq_regif_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_rdata_o (bus_rdata_o),
  .adc_start_o (adc_start_o),
  .adc_done_i  (adc_done_i),
  .dac_load_o  (dac_load_o),
  .st_conv     (st_conv),
  .st_settle   (st_settle)
);

// File: tb/tb_acq_regif.sv
`timescale 1ns/1ps
module tb_acq_regif;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic [3:0]  bus_addr_i = '0;
  logic        bus_wr_i = 0, bus_rd_i = 0, bus_byte_i = 0;
  logic [15:0] bus_wdata_i = '0;
  logic [15:0] bus_rdata_o;
  logic [15:0] din_i = '0;
  logic [15:0] dout_o;
  logic [12:0] ctrl_o;
  logic        adc_start_o;
  logic        adc_done_i = 0;
  logic [12:0] adc_data_i = '0;
  logic        dac_load_o;
  logic [2:0]  dac_chan_o;
  logic [11:0] dac_data_o;

  int checks = 0, errors = 0;
  int start_cnt = 0, load_cnt = 0;
  bit done_flag = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk_i = ~clk_i;

  acq_regif dut (.*);

  always @(posedge clk_i) begin
    if (adc_start_o) start_cnt++;
    if (dac_load_o)  load_cnt++;
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compare read data against scoreboard queue
  always @(negedge clk_i) begin
    #1;
    if (bus_rd_i) begin
      if (exp_q.size() == 0) check("SCOREBOARD_EMPTY", 1, 0);
      else check(tag_q.pop_front(), bus_rdata_o, exp_q.pop_front());
    end
  end

  task automatic bus_write(logic [3:0] a, logic [15:0] d, bit b = 0);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_byte_i = b; bus_wr_i = 1;
    @(negedge clk_i);
    bus_wr_i = 0; bus_byte_i = 0;
    @(negedge clk_i);
  endtask

  task automatic bus_read(logic [3:0] a, bit b, logic [15:0] exp, string tag);
    @(negedge clk_i);
    exp_q.push_back(exp); tag_q.push_back(tag);
    bus_addr_i = a; bus_byte_i = b; bus_rd_i = 1;
    @(negedge clk_i);
    bus_rd_i = 0; bus_byte_i = 0;
  endtask

  task automatic conv_done(logic [12:0] d);
    @(negedge clk_i);
    adc_done_i = 1; adc_data_i = d;
    @(negedge clk_i);
    adc_done_i = 0;
    @(negedge clk_i);
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #400000;
    check("WATCHDOG", 1, 0);
    finish_up();
  end

  initial begin
    int s0, l0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1
    check("R1 dout", dout_o, 0);
    check("R1 ctrl", ctrl_o, 0);
    bus_read(4'h6, 0, 16'h0000, "R1 status");
    // R2
    din_i = 16'hA55A;
    bus_write(4'h0, 16'h1234);
    check("R2 dout", dout_o, 16'h1234);
    bus_read(4'h0, 0, 16'hA55A, "R2 din read");
    // R3
    bus_write(4'h0, 16'hFFCD, 1);
    check("R3 dout byte", dout_o, 16'h12CD);
    // R4 / R9 no enable: no start
    s0 = start_cnt;
    bus_write(4'h6, 16'h0695);
    check("R4 ctrl fields", ctrl_o, 13'h0695);
    check("R9 no start without enable", start_cnt, s0);
    bus_write(4'h6, 16'hFF2A, 1);
    check("R3 ctrl byte", ctrl_o, 13'h062A);
    bus_write(4'h6, 16'h0695);
    // R5
    s0 = start_cnt;
    bus_write(4'h4, 16'hDEAD);
    check("R5 start pulse", start_cnt, s0 + 1);
    bus_read(4'h6, 0, 16'h0000, "R5 status busy");
    // R6 negative sample
    conv_done(13'h1ABC);
    bus_read(4'h6, 0, 16'h0010, "R6 status done");
    // R7 byte order
    bus_read(4'h4, 1, 16'h00FA, "R7 high byte");
    bus_read(4'h4, 1, 16'h00BC, "R7 low byte");
    bus_read(4'h4, 1, 16'h00FA, "R7 toggle high");
    // R5 start also clears bit 4 after it was set
    bus_write(4'h4, 16'h0000, 1);
    bus_read(4'h6, 0, 16'h0000, "R5 bit4 cleared");
    conv_done(13'h0123);
    bus_read(4'h4, 1, 16'h0001, "R7 pointer reset on start");
    bus_read(4'h4, 0, 16'h0123, "R8 word read positive");
    bus_read(4'h4, 1, 16'h0023, "R8 word read kept pointer");
    // R12
    conv_done(13'h0555);
    bus_read(4'h4, 0, 16'h0123, "R12 sample kept");
    bus_read(4'h6, 0, 16'h0010, "R12 status kept");
    // R9 settling
    s0 = start_cnt;
    bus_write(4'h6, 16'h06D5);
    check("R9 settle start", start_cnt, s0 + 1);
    bus_read(4'h6, 0, 16'h0010, "R9 bit3 clear");
    conv_done(13'h0FFF);
    bus_read(4'h6, 0, 16'h0018, "R9 bit3 set");
    bus_read(4'h4, 0, 16'h0123, "R9 sample kept");
    bus_write(4'h6, 16'h0695);
    bus_read(4'h6, 0, 16'h0010, "R9 bit3 cleared by write");
    // R10
    bus_write(4'h6, 16'h1803);
    l0 = load_cnt;
    bus_write(4'h2, 16'hF7A5);
    check("R10 load pulse", load_cnt, l0 + 1);
    check("R10 dac chan", dac_chan_o, 3);
    check("R10 dac data", dac_data_o, 12'h7A5);
    bus_write(4'h6, 16'h0003);
    l0 = load_cnt;
    bus_write(4'h2, 16'h0111);
    check("R10 no load when field clear", load_cnt, l0);
    check("R10 dac data kept", dac_data_o, 12'h7A5);
    // R11
    bus_write(4'h1, 16'hFFFF);
    bus_write(4'h8, 16'hFFFF);
    check("R11 dout unchanged", dout_o, 16'h12CD);
    bus_write(4'h7, 16'hFFFF);
    bus_write(4'hE, 16'hFFFF);
    check("R11 ctrl unchanged", ctrl_o, 13'h0003);
    bus_read(4'hA, 0, 16'h0000, "R11 unmapped read");
    bus_read(4'h3, 0, 16'h0000, "R11 odd read");
    repeat (3) @(negedge clk_i);
    finish_up();
  end
endmodule